// File: doc/BRIEF.md
# Counted-Transfer SPI Slave Port

This block is the slave end of an SPI link. While the master holds the slave-select line low, the block shifts one word out on MISO and one word in from MOSI, both on the master's SCK. Words are 8 or 16 bits long and travel MSB first. Clock polarity and clock phase can be set to any of the four SPI modes so the slave matches the master.

A parallel side serves a processor or a DMA engine. It loads the next transmit word into a one-word buffer, reads each received word, and writes the number of words the transfer should last. Every finished word lowers that count by one. The count reaching zero ends the transfer and raises a sticky done flag.

The port sends an all-zero word when no transmit word was waiting as a word begins, and records that as an underrun. A received word that replaces one nobody read is recorded as an overrun. SCK, slave-select and MOSI are brought into the system clock domain by synchronisers. Each high and low phase of SCK must last at least 6 system clocks.

Top module: `spiSlvTop`

## Requirements
- R1: On every word the slave shifts its transmit word out on `miso` and the master's `mosi` bits into a receive word at the same time, MSB first. The finished word appears on `rxData` with `rxValid` set, and `rxRead` clears `rxValid`.
- R2: `cpol` sets the SCK idle level. With `cpha`=0, MOSI is sampled on the leading (first) edge of each SCK period and MISO changes on the trailing edge. With `cpha`=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. All four combinations work.
- R3: `wideWord`=1 selects 16-bit words. `wideWord`=0 selects 8-bit words: bits 7:0 of `txData` are sent, bits 15:8 of `txData` are ignored, and bits 15:8 of `rxData` read as zero.
- R4: SCK edges have no effect while `ssN` is high, and none while the word count is zero. No word is received, and the count does not change.
- R5: Each completed word lowers `countLeft` by one. When it steps from 1 to 0 the transfer stops and `doneFlag` is set. `doneFlag` stays set, and `countLeft` never wraps below zero.
- R6: If the transmit buffer is empty when a word begins, the slave sends all zeros for that word and sets the sticky `underrun` flag.
- R7: If a word completes while `rxValid` is still set and `rxRead` is not asserted, the new word replaces the old one and the sticky `overrun` flag is set.
- R8: Raising `ssN` in the middle of a word aborts it. `countLeft` keeps its value, no received word is delivered, and the next word starts again from its first bit.
- R9: A `countLoad` pulse writes `countIn` into `countLeft` and clears `doneFlag`, `underrun` and `overrun`.
- R10: `miso` is held at 0 whenever no word is in progress, in particular whenever `countLeft` is zero.
- R11: `txFree` is 1 while the transmit buffer is empty. `txLoad` fills the buffer and clears `txFree`, and the start of a word takes the buffer contents and sets `txFree` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| wideWord | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| sck | input | 1 | Serial clock from the master |
| ssN | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| txData | input | DATA_W | Transmit word to load |
| txLoad | input | 1 | Writes `txData` into the transmit buffer |
| txFree | output | 1 | Transmit buffer is empty |
| rxData | output | DATA_W | Last received word |
| rxRead | input | 1 | Marks the received word as consumed |
| rxValid | output | 1 | A received word is waiting |
| countIn | input | COUNT_W | Word count to load |
| countLoad | input | 1 | Loads the count and clears the sticky flags |
| countLeft | output | COUNT_W | Words remaining in the transfer |
| doneFlag | output | 1 | Sticky: the count stepped from 1 to 0 |
| underrun | output | 1 | Sticky: a zero word was sent for lack of data |
| overrun | output | 1 | Sticky: an unread received word was replaced |

## Verification
The bench builds the block with its defaults: 16-bit data, an 8-bit narrow size, an 8-bit count and two synchroniser stages. Because word size and clock format are run-time inputs, this one build reaches both word sizes and all four SPI modes. The bench runs SCK at 16 system clocks per period, which leaves margin over the synchroniser delay in front of MISO. The short count values used still reach the 1-to-0 step, a count of zero, and an abort that leaves the count in the middle of a transfer.

// File: rtl/spiSlvPkg.sv
package spiSlvPkg;
  // Strobes from the control unit to the datapath, valid for one clock
  typedef struct packed {
    logic loadTx;    // a word begins: move buffer (or zeros) into the shifter
    logic shiftOut;  // launch edge: present the next transmit bit
    logic sampleIn;  // sample edge: take one MOSI bit
    logic wordDone;  // last sample of the word
    logic active;    // a word is in progress
    logic clrFlags;  // clear the sticky status flags
  } spiStrobeT;
endpackage

// File: rtl/spiSlvSync.sv
module spiSlvSync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rstVal,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= rstVal;
        else       pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= rstVal;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spiSlvCtrl.sv
module spiSlvCtrl
  import spiSlvPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int COUNT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               wideWord,
  input  logic               sckS,
  input  logic               ssS,
  input  logic [COUNT_W-1:0] countIn,
  input  logic               countLoad,
  output spiStrobeT          stb,
  output logic [COUNT_W-1:0] countLeft,
  output logic               doneFlag
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LAST_WIDE   = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_NARROW = BW'(NARROW_W - 1);

  logic          sckPrev;
  logic          inWord;
  logic [BW-1:0] bitCnt;
  logic          riseEdge, fallEdge, leadEdge, trailEdge;
  logic          sampleEdge, launchEdge;
  logic          startWord, abortWord, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= cpol;
    else       sckPrev <= sckS;
  end

  always_comb begin
    riseEdge   = sckS & ~sckPrev;
    fallEdge   = ~sckS & sckPrev;
    leadEdge   = cpol ? fallEdge : riseEdge;
    trailEdge  = cpol ? riseEdge : fallEdge;
    sampleEdge = cpha ? trailEdge : leadEdge;
    launchEdge = cpha ? leadEdge : trailEdge;
    lastBit    = bitCnt == (wideWord ? LAST_WIDE : LAST_NARROW);
    startWord  = !inWord && !ssS && (countLeft != '0) && !countLoad;
    abortWord  = inWord && ssS;

    stb.loadTx   = startWord;
    stb.sampleIn = inWord && !ssS && sampleEdge;
    // first launch edge of a word is skipped: its MSB is already on the line
    stb.shiftOut = inWord && !ssS && launchEdge && (bitCnt != '0);
    stb.wordDone = stb.sampleIn && lastBit;
    stb.active   = inWord;
    stb.clrFlags = countLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWord    <= 1'b0;
      bitCnt    <= '0;
      countLeft <= '0;
      doneFlag  <= 1'b0;
    end else if (countLoad) begin
      inWord    <= 1'b0;
      bitCnt    <= '0;
      countLeft <= countIn;
      doneFlag  <= 1'b0;
    end else if (abortWord) begin
      inWord <= 1'b0;
      bitCnt <= '0;
    end else if (startWord) begin
      inWord <= 1'b1;
      bitCnt <= '0;
    end else if (stb.wordDone) begin
      inWord    <= 1'b0;
      bitCnt    <= '0;
      countLeft <= countLeft - COUNT_W'(1);
      if (countLeft == COUNT_W'(1)) doneFlag <= 1'b1;
    end else if (stb.sampleIn) begin
      bitCnt <= bitCnt + BW'(1);
    end
  end
endmodule

// File: rtl/spiSlvData.sv
module spiSlvData
  import spiSlvPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideWord,
  input  spiStrobeT         stb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  input  logic              rxRead,
  output logic              miso,
  output logic              txFree,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              underrun,
  output logic              overrun
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] txBuf, txShift, rxShift, rxNext, rxWord;
  logic              txFull;

  always_comb begin
    rxNext = {rxShift[DATA_W-2:0], mosiS};
    rxWord = wideWord ? rxNext : (rxNext & NARROW_MASK);
    miso   = stb.active ? (wideWord ? txShift[DATA_W-1] : txShift[NARROW_W-1]) : 1'b0;
    txFree = !txFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      txFull   <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (txLoad) txBuf <= txData;

      if (txLoad)          txFull <= 1'b1;
      else if (stb.loadTx) txFull <= 1'b0;

      if (stb.loadTx)        txShift <= txFull ? txBuf : '0;
      else if (stb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (stb.sampleIn) rxShift <= rxNext;
      if (stb.wordDone) rxData  <= rxWord;

      if (stb.wordDone) rxValid <= 1'b1;
      else if (rxRead)  rxValid <= 1'b0;

      if (stb.clrFlags)                  underrun <= 1'b0;
      else if (stb.loadTx && !txFull)    underrun <= 1'b1;

      if (stb.clrFlags)                             overrun <= 1'b0;
      else if (stb.wordDone && rxValid && !rxRead)  overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/spiSlvTop.sv
module spiSlvTop
  import spiSlvPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               wideWord,
  input  logic               sck,
  input  logic               ssN,
  input  logic               mosi,
  output logic               miso,
  input  logic [DATA_W-1:0]  txData,
  input  logic               txLoad,
  output logic               txFree,
  output logic [DATA_W-1:0]  rxData,
  input  logic               rxRead,
  output logic               rxValid,
  input  logic [COUNT_W-1:0] countIn,
  input  logic               countLoad,
  output logic [COUNT_W-1:0] countLeft,
  output logic               doneFlag,
  output logic               underrun,
  output logic               overrun
);
  logic [2:0] pinSync;
  spiStrobeT  stb;

  spiSlvSync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .din    ({sck, ssN, mosi}),
    .rstVal ({cpol, 1'b1, 1'b0}),
    .dout   (pinSync)
  );

  spiSlvCtrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .COUNT_W(COUNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpol      (cpol),
    .cpha      (cpha),
    .wideWord  (wideWord),
    .sckS      (pinSync[2]),
    .ssS       (pinSync[1]),
    .countIn   (countIn),
    .countLoad (countLoad),
    .stb       (stb),
    .countLeft (countLeft),
    .doneFlag  (doneFlag)
  );

  spiSlvData #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .wideWord (wideWord),
    .stb      (stb),
    .mosiS    (pinSync[0]),
    .txData   (txData),
    .txLoad   (txLoad),
    .rxRead   (rxRead),
    .miso     (miso),
    .txFree   (txFree),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .underrun (underrun),
    .overrun  (overrun)
  );
endmodule

// File: rtl/spiSlvChk.sv
module spiSlvChk #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               ssN,
  input logic               miso,
  input logic [COUNT_W-1:0] countIn,
  input logic               countLoad,
  input logic [COUNT_W-1:0] countLeft,
  input logic               doneFlag,
  input logic               underrun,
  input logic               overrun
);
  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (countLeft == '0) |-> !miso); // R10

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    !countLoad |=> (countLeft == $past(countLeft) || countLeft == $past(countLeft) - COUNT_W'(1))); // R5

  AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!countLoad && countLeft == '0) |=> (countLeft == '0)); // R5

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!countLoad && countLeft == COUNT_W'(1)) |=> (countLeft != '0 || doneFlag)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !countLoad) |=> doneFlag); // R5

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    countLoad |=> (!doneFlag && !underrun && !overrun && countLeft == $past(countIn))); // R9

  AST_DESELECT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $past(ssN, 2) && !countLoad) |=> $stable(countLeft)); // R8
endmodule

bind spiSlvTop spiSlvChk #(.COUNT_W(COUNT_W)) i_spiSlvChk (
  .clk       (clk),
  .rstN      (rstN),
  .ssN       (ssN),
  .miso      (miso),
  .countIn   (countIn),
  .countLoad (countLoad),
  .countLeft (countLeft),
  .doneFlag  (doneFlag),
  .underrun  (underrun),
  .overrun   (overrun)
);

// File: tb/test_spiSlvTop.sv
`timescale 1ns/1ps
module test_spiSlvTop;
  localparam int HP = 8; // SCK half period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, wideWord = 1'b1;
  logic sck = 1'b0, ssN = 1'b1, mosi = 1'b0;
  logic [15:0] txData = '0;
  logic txLoad = 1'b0, rxRead = 1'b0, countLoad = 1'b0;
  logic [7:0] countIn = '0;
  logic miso, txFree, rxValid, doneFlag, underrun, overrun;
  logic [15:0] rxData;
  logic [7:0] countLeft;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spiSlvTop i_spiSlvTop (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .wideWord(wideWord),
    .sck(sck), .ssN(ssN), .mosi(mosi), .miso(miso),
    .txData(txData), .txLoad(txLoad), .txFree(txFree),
    .rxData(rxData), .rxRead(rxRead), .rxValid(rxValid),
    .countIn(countIn), .countLoad(countLoad), .countLeft(countLeft),
    .doneFlag(doneFlag), .underrun(underrun), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCount(input logic [7:0] v);
    @(negedge clk); countIn = v; countLoad = 1'b1;
    @(negedge clk); countLoad = 1'b0;
  endtask

  task automatic loadTx(input logic [15:0] v);
    @(negedge clk); txData = v; txLoad = 1'b1;
    @(negedge clk); txLoad = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic setMode(input logic pol, input logic pha, input logic wide);
    @(negedge clk); cpol = pol; cpha = pha; wideWord = wide; sck = pol; mosi = 1'b0;
    waitClk(8);
  endtask

  task automatic selectLow();
    @(negedge clk); ssN = 1'b0; waitClk(8);
  endtask

  task automatic selectHigh();
    @(negedge clk); ssN = 1'b1; waitClk(8);
  endtask

  // Master side: nb bits of mo, MSB first; returns what came back on miso
  task automatic xfer(input logic [15:0] mo, input int nb, output logic [15:0] mi);
    mi = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = mo[i];
        waitClk(HP);
        mi[i] = miso;
        sck = ~cpol;
        waitClk(HP);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[i];
        waitClk(HP);
        mi[i] = miso;
        sck = cpol;
        waitClk(HP);
      end
    end
    waitClk(6);
  endtask

  task automatic testReset();
    chk("R10", "miso after reset", miso, 0);
    chk("R1", "rxValid after reset", rxValid, 0);
    chk("R5", "countLeft after reset", countLeft, 0);
    chk("R5", "doneFlag after reset", doneFlag, 0);
    chk("R11", "txFree after reset", txFree, 1);
    chk("R6", "underrun after reset", underrun, 0);
    chk("R7", "overrun after reset", overrun, 0);
  endtask

  task automatic testMode0Wide();
    logic [15:0] mi;
    setMode(1'b0, 1'b0, 1'b1);
    setCount(8'd2);
    loadTx(16'hA5C3);
    chk("R11", "txFree after load", txFree, 0);
    selectLow();
    chk("R11", "txFree after word start", txFree, 1);
    loadTx(16'h5A0F);
    xfer(16'h1234, 16, mi);
    chk("R1", "mode0 miso word 1", mi, 16'hA5C3);
    chk("R1", "mode0 rxValid", rxValid, 1);
    chk("R1", "mode0 rxData word 1", rxData, 16'h1234);
    chk("R5", "count after word 1", countLeft, 1);
    chk("R5", "done not yet", doneFlag, 0);
    readRx();
    chk("R1", "rxRead clears rxValid", rxValid, 0);
    xfer(16'hBEEF, 16, mi);
    chk("R1", "mode0 miso word 2", mi, 16'h5A0F);
    chk("R1", "mode0 rxData word 2", rxData, 16'hBEEF);
    chk("R5", "count after last word", countLeft, 0);
    chk("R5", "done after 1 to 0", doneFlag, 1);
    chk("R6", "no underrun with data", underrun, 0);
    chk("R7", "no overrun when read", overrun, 0);
    chk("R10", "miso idle after transfer", miso, 0);
    selectHigh();
    readRx();
  endtask

  task automatic testUnderrunMode3();
    logic [15:0] mi;
    setMode(1'b1, 1'b1, 1'b0);
    setCount(8'd1);
    chk("R9", "countLoad clears done", doneFlag, 0);
    selectLow();
    xfer(16'h0096, 8, mi);
    chk("R6", "zero word sent", mi, 16'h0000);
    chk("R6", "underrun set", underrun, 1);
    chk("R3", "narrow rxData upper zero", rxData, 16'h0096);
    chk("R2", "mode3 count stepped", countLeft, 0);
    selectHigh();
    readRx();
    setCount(8'd0);
    chk("R9", "countLoad clears underrun", underrun, 0);
  endtask

  task automatic testOverrunMode1();
    logic [15:0] mi;
    setMode(1'b0, 1'b1, 1'b0);
    setCount(8'd2);
    loadTx(16'hFF3C);
    selectLow();
    loadTx(16'h00C3);
    xfer(16'h0011, 8, mi);
    chk("R3", "narrow send ignores upper byte", mi, 16'h003C);
    chk("R2", "mode1 rxData word 1", rxData, 16'h0011);
    xfer(16'h0022, 8, mi);
    chk("R2", "mode1 miso word 2", mi, 16'h00C3);
    chk("R7", "overrun set", overrun, 1);
    chk("R7", "newest word kept", rxData, 16'h0022);
    chk("R6", "no underrun", underrun, 0);
    selectHigh();
    readRx();
    setCount(8'd0);
    chk("R9", "countLoad clears overrun", overrun, 0);
  endtask

  task automatic testAbortMode2();
    logic [15:0] mi;
    setMode(1'b1, 1'b0, 1'b1);
    setCount(8'd2);
    loadTx(16'h1357);
    selectLow();
    xfer(16'h001F, 5, mi);
    selectHigh();
    chk("R8", "abort keeps count", countLeft, 2);
    chk("R8", "abort delivers no word", rxValid, 0);
    chk("R8", "abort no done", doneFlag, 0);
    loadTx(16'h2468);
    selectLow();
    xfer(16'hC0DE, 16, mi);
    chk("R8", "restart from first bit miso", mi, 16'h2468);
    chk("R2", "mode2 rxData", rxData, 16'hC0DE);
    chk("R8", "count after restart word", countLeft, 1);
    selectHigh();
    readRx();
  endtask

  task automatic testIgnored();
    logic [15:0] mi;
    setMode(1'b0, 1'b0, 1'b1);
    setCount(8'd0);
    selectLow();
    xfer(16'hFFFF, 16, mi);
    chk("R4", "count zero: no word", rxValid, 0);
    chk("R10", "count zero: miso low", mi, 16'h0000);
    chk("R4", "count zero stays", countLeft, 0);
    selectHigh();
    setCount(8'd1);
    xfer(16'hAAAA, 16, mi);
    chk("R4", "deselected: no word", rxValid, 0);
    chk("R4", "deselected: count held", countLeft, 1);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testMode0Wide();
    testUnderrunMode3();
    testOverrunMode1();
    testAbortMode2();
    testIgnored();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule